// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Controller (Clock Modes 0 and 3)

This block is the controller side of a four-wire serial peripheral link. It moves 8-bit words in both directions at once over one serial clock output, one data output and one data input. Software loads bytes into a four-entry transmit queue and collects the bytes shifted in from a four-entry receive queue. Each byte is sent most significant bit first, and the matching received byte is queued automatically once its eighth bit has been captured. Chip select is not part of this block and is driven elsewhere as an ordinary output.

The serial clock comes from a clock-enable generator with a fractional divisor D = integer + fraction/256. Each bit lasts four enables, so the serial clock runs at the core rate divided by 4·D. Only clock mode 0 (idle low, capture on the rising edge) and clock mode 3 (idle high, capture on the rising edge after a falling-edge update) are accepted. Any other request is refused and leaves the engine switched off with an error flag raised. A counter tracks how many bytes have been written but not yet read back, and it blocks the writer at four. Because of this limit the receive queue can never overflow.

A flush pulse starts a new transfer chunk. It empties both queues, zeroes the outstanding count and returns the line to its idle level. For a receive-only transfer, software writes zero bytes. For a transmit-only transfer, software reads and discards the returned bytes.

Top module: `spi_m03_engine`

## Requirements
- R1: After reset, sclk and mosi are 0, cfg_ok and cfg_err are 0, rx_empty is 1, and busy and tx_full are 0.
- R2: A cfg_write pulse is accepted (cfg_ok=1, cfg_err=0) only if all of these hold: cfg_mode is 2'd0 or 2'd3, cfg_lsb_first=0, cfg_word_bits=8, cfg_target=0, cfg_loopback=0, cfg_half_duplex=0, cfg_lanes=2'd0 and cfg_div_int≥1. Any other pulse gives cfg_ok=0 and cfg_err=1, and sclk then does not toggle even when bytes are queued.
- R3: One bit lasts four enables of a divider with D = cfg_div_int + cfg_div_frac/256. With an integer D during a continuous stream, successive rising sclk edges are exactly 4·D core cycles apart. With D=1.5, one byte takes exactly 48 cycles.
- R4: In mode 0 (cfg_mode=2'd0), sclk idles low and each bit is low for two enables and then high for two. miso is captured as sclk rises, and mosi changes only in cycles where sclk is low.
- R5: In mode 3 (cfg_mode=2'd3), sclk idles high. Each bit is high for one enable, low for two (mosi is updated as sclk falls), then rises for one enable, when miso is captured.
- R6: Words are 8 bits and are shifted most significant bit first in both directions. The queued byte order matches the wire order.
- R7: The outstanding count goes up on each accepted push and down on each accepted pop. tx_full is 1 when the count is 4 or the transmit queue is full, and a push while tx_full is 1 is ignored.
- R8: If the transmit queue is empty at a word boundary, the engine stops with sclk at its idle level. busy is 1 while a word is shifting or the transmit queue holds data.
- R9: flush or cfg_write empties both queues, zeroes the outstanding count, stops the engine and drives mosi to 0.
- R10: rx_data shows the oldest received byte while rx_empty is 0. A pop while rx_empty is 1 is ignored and does not change the outstanding count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write | input | 1 | Pulse that applies the configuration inputs |
| cfg_mode | input | 2 | Clock mode number: 0 or 3 are accepted |
| cfg_lsb_first | input | 1 | Request for least-significant-first order (refused) |
| cfg_word_bits | input | 6 | Requested word length; must be 8 |
| cfg_target | input | 1 | Request for target operation (refused) |
| cfg_loopback | input | 1 | Request for internal loopback (refused) |
| cfg_half_duplex | input | 1 | Request for half-duplex operation (refused) |
| cfg_lanes | input | 2 | Data line count code; only 0 (single) is accepted |
| cfg_div_int | input | 16 | Integer part of the divisor; must be at least 1 |
| cfg_div_frac | input | 8 | Fractional part of the divisor, in 1/256 units |
| cfg_ok | output | 1 | Engine enabled by the last accepted configuration |
| cfg_err | output | 1 | Last configuration pulse was refused |
| flush | input | 1 | Start-of-chunk clear of both queues and the engine |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Push is blocked (outstanding limit or queue full) |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue is empty |
| busy | output | 1 | Word shifting or transmit queue not empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
If the bit-phase sequencer is off by one state, the fault shows on sclk within a single bit. The rising-edge spacing is no longer 4·D cycles, or the idle level is wrong as soon as the line goes quiet. A corrupted shift register or bit counter becomes visible after eight captured bits, as a wrong byte at rx_data or as a byte pair assembled from the captured mosi stream. A drifting outstanding counter becomes visible on the very next push, through tx_full rising one byte too early or too late. Sweeping both modes over several divisors lets each kind of fault surface in a separate scenario.

// File: rtl/spi03_pkg.sv
package spi03_pkg;
  // Quarter-bit phases of one serial bit; each phase lasts one divider enable.
  typedef enum logic [1:0] {PH_A, PH_B, PH_C, PH_D} phase_t;
  localparam int TICKS_PER_BIT = 4;
endpackage

// File: rtl/spi03_tick_gen.sv
module spi03_tick_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int ACC_W = INT_W + FRAC_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] div_full;

  assign div_full = {1'b0, div_int, div_frac};
  assign sum      = acc_q + ONE;

  // Accumulate one unit per core cycle; emit an enable whenever the divisor is reached.
  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (sum >= div_full) begin
      acc_q <= sum - div_full;
      tick  <= 1'b1;
    end else begin
      acc_q <= sum;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi03_fifo.sv
module spi03_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  // DEPTH is a power of two; pointers carry one wrap bit.
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_q, rd_q;

  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign dout  = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push && !full) wr_q <= wr_q + 1'b1;
      if (pop && !empty) rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi03_shifter.sv
module spi03_shifter import spi03_pkg::*; #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              cpol,
  input  logic              tick,
  input  logic              tx_avail,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_take,
  input  logic              miso,
  output logic              rx_put,
  output logic [WORD_W-1:0] rx_word,
  output logic              active,
  output logic              sclk,
  output logic              mosi
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  phase_t            ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;
  logic              hold_q;
  logic              step;
  logic              at_boundary;
  logic              sample_now;

  assign step        = tick && run;
  assign at_boundary = !active || (ph_q == PH_D && bit_q == LAST_BIT);
  assign tx_take     = step && at_boundary && tx_avail;
  // Mode 0 captures on entering phase C, mode 3 on entering phase D.
  assign sample_now  = step && active && (cpol ? (ph_q == PH_C) : (ph_q == PH_B));
  assign rx_put      = sample_now && (bit_q == LAST_BIT);
  assign rx_word     = {sh_q[WORD_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ph_q   <= PH_A;
      bit_q  <= '0;
      sh_q   <= '0;
      hold_q <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
    end else if (clr) begin
      active <= 1'b0;
      ph_q   <= PH_A;
      bit_q  <= '0;
      sh_q   <= '0;
      hold_q <= 1'b0;
      sclk   <= cpol;
      mosi   <= 1'b0;
    end else if (step && at_boundary) begin
      if (tx_avail) begin
        active <= 1'b1;
        ph_q   <= PH_A;
        bit_q  <= '0;
        sh_q   <= tx_word;
        if (cpol) begin
          sclk   <= 1'b1;
          hold_q <= tx_word[WORD_W-1];
        end else begin
          sclk <= 1'b0;
          mosi <= tx_word[WORD_W-1];
        end
      end else begin
        active <= 1'b0;
        sclk   <= cpol;
      end
    end else if (step) begin
      unique case (ph_q)
        PH_A: begin
          ph_q <= PH_B;
          if (cpol) begin
            sclk <= 1'b0;
            mosi <= hold_q;
          end
        end
        PH_B: begin
          ph_q <= PH_C;
          if (!cpol) begin
            sclk <= 1'b1;
            sh_q <= rx_word;
          end
        end
        PH_C: begin
          ph_q <= PH_D;
          if (cpol) begin
            sclk <= 1'b1;
            sh_q <= rx_word;
          end
        end
        PH_D: begin
          ph_q  <= PH_A;
          bit_q <= bit_q + 1'b1;
          if (cpol) begin
            sclk   <= 1'b1;
            hold_q <= sh_q[WORD_W-1];
          end else begin
            sclk <= 1'b0;
            mosi <= sh_q[WORD_W-1];
          end
        end
      endcase
    end else if (!active) begin
      sclk <= cpol;
    end
  end
endmodule

// File: rtl/spi_m03_engine.sv
module spi_m03_engine #(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int MAX_AHEAD  = 4,
  parameter int DIV_INT_W  = 16,
  parameter int DIV_FRAC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_write,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_lsb_first,
  input  logic [5:0]            cfg_word_bits,
  input  logic                  cfg_target,
  input  logic                  cfg_loopback,
  input  logic                  cfg_half_duplex,
  input  logic [1:0]            cfg_lanes,
  input  logic [DIV_INT_W-1:0]  cfg_div_int,
  input  logic [DIV_FRAC_W-1:0] cfg_div_frac,
  output logic                  cfg_ok,
  output logic                  cfg_err,
  input  logic                  flush,
  input  logic                  tx_push,
  input  logic [WORD_W-1:0]     tx_data,
  output logic                  tx_full,
  input  logic                  rx_pop,
  output logic [WORD_W-1:0]     rx_data,
  output logic                  rx_empty,
  output logic                  busy,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int CNT_W = $clog2(MAX_AHEAD + 1);

  logic                  mode3_q;
  logic [DIV_INT_W-1:0]  div_int_q;
  logic [DIV_FRAC_W-1:0] div_frac_q;
  logic                  cfg_valid;
  logic                  clr;
  logic [CNT_W-1:0]      ahead_q;
  logic                  push_ok, pop_ok;
  logic                  txf_full, txf_empty, rxf_full;
  logic [WORD_W-1:0]     txf_head;
  logic                  tick, tx_take, rx_put, eng_active;
  logic [WORD_W-1:0]     rx_word;

  assign cfg_valid = ((cfg_mode == 2'd0) || (cfg_mode == 2'd3)) && !cfg_lsb_first &&
                     (cfg_word_bits == 6'(WORD_W)) && !cfg_target && !cfg_loopback &&
                     !cfg_half_duplex && (cfg_lanes == 2'd0) && (cfg_div_int != '0);
  assign clr = flush || cfg_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ok     <= 1'b0;
      cfg_err    <= 1'b0;
      mode3_q    <= 1'b0;
      div_int_q  <= '0;
      div_frac_q <= '0;
    end else if (cfg_write) begin
      cfg_ok  <= cfg_valid;
      cfg_err <= !cfg_valid;
      if (cfg_valid) begin
        mode3_q    <= cfg_mode[0];
        div_int_q  <= cfg_div_int;
        div_frac_q <= cfg_div_frac;
      end
    end
  end

  // Bytes written but not yet read back.
  assign tx_full = (ahead_q == CNT_W'(MAX_AHEAD)) || txf_full;
  assign push_ok = tx_push && !tx_full;
  assign pop_ok  = rx_pop && !rx_empty;

  always_ff @(posedge clk) begin
    if (rst || clr) ahead_q <= '0;
    else if (push_ok && !pop_ok) ahead_q <= ahead_q + 1'b1;
    else if (pop_ok && !push_ok) ahead_q <= ahead_q - 1'b1;
  end

  assign busy = eng_active || !txf_empty;

  spi03_tick_gen #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) i_tick (
    .clk(clk), .rst(rst), .clr(clr), .run(cfg_ok),
    .div_int(div_int_q), .div_frac(div_frac_q), .tick(tick)
  );

  spi03_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst(rst), .clr(clr), .push(push_ok), .din(tx_data),
    .pop(tx_take), .dout(txf_head), .full(txf_full), .empty(txf_empty)
  );

  spi03_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .clr(clr), .push(rx_put), .din(rx_word),
    .pop(pop_ok), .dout(rx_data), .full(rxf_full), .empty(rx_empty)
  );

  spi03_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .clr(clr), .run(cfg_ok), .cpol(mode3_q), .tick(tick),
    .tx_avail(!txf_empty), .tx_word(txf_head), .tx_take(tx_take),
    .miso(miso), .rx_put(rx_put), .rx_word(rx_word), .active(eng_active),
    .sclk(sclk), .mosi(mosi)
  );
endmodule

// File: rtl/spi03_checker.sv
module spi03_checker #(
  parameter int MAX_AHEAD = 4,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             cfg_write,
  input logic             cfg_ok,
  input logic             tx_push,
  input logic             tx_full,
  input logic             rx_pop,
  input logic             sclk,
  input logic             mosi,
  input logic             mode3,
  input logic             eng_active,
  input logic             rx_put,
  input logic             rxf_full,
  input logic [CNT_W-1:0] ahead
);
  logic clr;
  assign clr = flush || cfg_write;

  // R8: a stopped engine rests at the idle level of the selected mode
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!eng_active && !$past(eng_active) && !$past(clr)) |-> (sclk == mode3))
    else $error("idle sclk level wrong");

  // R4, R5: data out only moves while the serial clock is low
  assert_mosi_low_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mosi) && !$past(clr)) |-> !sclk)
    else $error("mosi moved with sclk high");

  // R2: a refused configuration keeps the clock quiet
  assert_quiet_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ok && !cfg_write) |=> $stable(sclk))
    else $error("sclk toggled while disabled");

  // R7: outstanding count never exceeds the limit
  assert_ahead_cap_R7: assert property (@(posedge clk) disable iff (rst)
    ahead <= CNT_W'(MAX_AHEAD))
    else $error("outstanding count over limit");

  // R7: a blocked push leaves the count alone
  assert_blocked_push_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_push && !rx_pop && !clr) |=> $stable(ahead))
    else $error("blocked push changed count");

  // R10: the receive queue always has room for a finished word
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    rx_put |-> !rxf_full)
    else $error("receive queue overflow");
endmodule

bind spi_m03_engine spi03_checker #(.MAX_AHEAD(MAX_AHEAD), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .flush(flush), .cfg_write(cfg_write), .cfg_ok(cfg_ok),
  .tx_push(tx_push), .tx_full(tx_full), .rx_pop(rx_pop), .sclk(sclk), .mosi(mosi),
  .mode3(mode3_q), .eng_active(eng_active), .rx_put(rx_put), .rxf_full(rxf_full),
  .ahead(ahead_q)
);

// File: tb/test_spi_m03_engine.sv
module test_spi_m03_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_write = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_lsb_first = 1'b0;
  logic [5:0] cfg_word_bits = 6'd8;
  logic       cfg_target = 1'b0;
  logic       cfg_loopback = 1'b0;
  logic       cfg_half_duplex = 1'b0;
  logic [1:0] cfg_lanes = 2'd0;
  logic [15:0] cfg_div_int = 16'd1;
  logic [7:0] cfg_div_frac = 8'd0;
  logic       cfg_ok, cfg_err;
  logic       flush = 1'b0;
  logic       tx_push = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_full;
  logic       rx_pop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_empty, busy, sclk, mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_m03_engine i_spi_m03_engine (
    .clk(clk), .rst(rst), .cfg_write(cfg_write), .cfg_mode(cfg_mode),
    .cfg_lsb_first(cfg_lsb_first), .cfg_word_bits(cfg_word_bits), .cfg_target(cfg_target),
    .cfg_loopback(cfg_loopback), .cfg_half_duplex(cfg_half_duplex), .cfg_lanes(cfg_lanes),
    .cfg_div_int(cfg_div_int), .cfg_div_frac(cfg_div_frac), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
    .flush(flush), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] slave_byte(input int i);
    return 8'((i * 37 + 91) % 256);
  endfunction

  function automatic logic [7:0] tx_byte(input int i);
    return 8'((i * 53 + 17) % 256);
  endfunction

  // Target model: records mosi and rise times at each rising sclk, presents next miso bit after it.
  int cyc = 0;
  int rise_cnt = 0;
  int base = 0;
  int rise_t [0:1023];
  logic mosi_bit [0:1023];
  logic sclk_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    int idx;
    logic [7:0] b;
    if (sclk && !sclk_d) begin
      idx = rise_cnt - base;
      if (idx >= 0 && idx < 1024) begin
        rise_t[idx]   = cyc;
        mosi_bit[idx] = mosi;
      end
      rise_cnt = rise_cnt + 1;
    end
    sclk_d = sclk;
    idx  = rise_cnt - base;
    b    = slave_byte(idx / 8);
    miso = b[7 - (idx % 8)];
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] m, input logic lsb, input logic [5:0] bits,
                        input logic tgt, input logic lp, input logic hd, input logic [1:0] ln,
                        input logic [15:0] di, input logic [7:0] df);
    @(negedge clk);
    cfg_mode = m; cfg_lsb_first = lsb; cfg_word_bits = bits; cfg_target = tgt;
    cfg_loopback = lp; cfg_half_duplex = hd; cfg_lanes = ln;
    cfg_div_int = di; cfg_div_frac = df; cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic good_cfg(input logic [1:0] m, input logic [15:0] di, input logic [7:0] df);
    do_cfg(m, 1'b0, 6'd8, 1'b0, 1'b0, 1'b0, 2'd0, di, df);
  endtask

  task automatic slave_sync();
    @(posedge clk);
    #1;
    base = rise_cnt;
  endtask

  task automatic push1(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop1(input string req, input int exp);
    @(negedge clk);
    chk_eq(req, "rx byte", int'(rx_data), exp);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  // Streams n bytes with overlapped pushes and pops, then checks data and clock spacing.
  task automatic run_stream(input int n, input int bit_cyc, input int byte_cyc, input string req);
    int pushed = 0;
    int popped = 0;
    int guard  = 0;
    int bad    = 0;
    while (popped < n && guard < 20000) begin
      @(negedge clk);
      guard++;
      tx_push = 1'b0;
      rx_pop  = 1'b0;
      if (!rx_empty) begin
        chk_eq("R6", "received byte", int'(rx_data), int'(slave_byte(popped)));
        rx_pop = 1'b1;
        popped++;
      end
      if (!tx_full && pushed < n) begin
        tx_data = tx_byte(pushed);
        tx_push = 1'b1;
        pushed++;
      end
    end
    @(negedge clk);
    tx_push = 1'b0;
    rx_pop  = 1'b0;
    chk_eq("R6", "bytes returned", popped, n);
    for (int j = 0; j < n; j++) begin
      logic [7:0] w;
      for (int k = 0; k < 8; k++) w[7-k] = mosi_bit[8*j + k];
      chk_eq("R6", "wire byte", int'(w), int'(tx_byte(j)));
    end
    if (bit_cyc > 0)
      for (int i = 1; i < 8*n; i++) if (rise_t[i] - rise_t[i-1] != bit_cyc) bad++;
    for (int j = 1; j < n; j++) if (rise_t[8*j] - rise_t[8*(j-1)] != byte_cyc) bad++;
    chk_eq("R3", "sclk spacing mismatches", bad, 0);
    repeat (40) @(negedge clk);
    chk_eq(req, "idle sclk after stream", int'(sclk), int'(cfg_mode == 2'd3));
    chk_eq("R8", "busy after stream", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1", "sclk", int'(sclk), 0);
    chk_eq("R1", "mosi", int'(mosi), 0);
    chk_eq("R1", "cfg_ok", int'(cfg_ok), 0);
    chk_eq("R1", "cfg_err", int'(cfg_err), 0);
    chk_eq("R1", "rx_empty", int'(rx_empty), 1);
    chk_eq("R1", "busy", int'(busy), 0);
    chk_eq("R1", "tx_full", int'(tx_full), 0);

    // R2 refused configurations
    for (int c = 0; c < 10; c++) begin
      case (c)
        0: do_cfg(2'd1, 0, 6'd8, 0, 0, 0, 2'd0, 16'd1, 8'd0);
        1: do_cfg(2'd2, 0, 6'd8, 0, 0, 0, 2'd0, 16'd1, 8'd0);
        2: do_cfg(2'd0, 1, 6'd8, 0, 0, 0, 2'd0, 16'd1, 8'd0);
        3: do_cfg(2'd0, 0, 6'd7, 0, 0, 0, 2'd0, 16'd1, 8'd0);
        4: do_cfg(2'd3, 0, 6'd16, 0, 0, 0, 2'd0, 16'd1, 8'd0);
        5: do_cfg(2'd0, 0, 6'd8, 1, 0, 0, 2'd0, 16'd1, 8'd0);
        6: do_cfg(2'd0, 0, 6'd8, 0, 1, 0, 2'd0, 16'd1, 8'd0);
        7: do_cfg(2'd3, 0, 6'd8, 0, 0, 1, 2'd0, 16'd1, 8'd0);
        8: do_cfg(2'd0, 0, 6'd8, 0, 0, 0, 2'd1, 16'd1, 8'd0);
        default: do_cfg(2'd0, 0, 6'd8, 0, 0, 0, 2'd0, 16'd0, 8'd200);
      endcase
      chk_eq("R2", $sformatf("case %0d cfg_ok", c), int'(cfg_ok), 0);
      chk_eq("R2", $sformatf("case %0d cfg_err", c), int'(cfg_err), 1);
    end
    slave_sync();
    push1(8'hA5);
    repeat (100) @(negedge clk);
    chk_eq("R2", "rises while refused", rise_cnt - base, 0);
    chk_eq("R8", "busy with queued byte", int'(busy), 1);
    chk_eq("R2", "rx_empty while refused", int'(rx_empty), 1);
    good_cfg(2'd0, 16'd1, 8'd0);
    chk_eq("R2", "accepted cfg_ok", int'(cfg_ok), 1);
    chk_eq("R2", "accepted cfg_err", int'(cfg_err), 0);
    chk_eq("R9", "cfg_write clears queue", int'(busy), 0);

    // R4, R5, R3, R6 sweep over modes and integer divisors
    for (int m = 0; m < 2; m++) begin
      for (int d = 1; d <= 3; d++) begin
        good_cfg(m ? 2'd3 : 2'd0, 16'(d), 8'd0);
        chk_eq(m ? "R5" : "R4", "idle sclk", int'(sclk), m);
        chk_eq("R9", "mosi low after cfg", int'(mosi), 0);
        slave_sync();
        run_stream(6, 4*d, 32*d, m ? "R5" : "R4");
      end
    end

    // R3 fractional divisor 1.5
    good_cfg(2'd3, 16'd1, 8'd128);
    slave_sync();
    run_stream(3, 0, 48, "R5");

    // R7 outstanding limit and ignored push
    good_cfg(2'd0, 16'd1, 8'd0);
    slave_sync();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_eq("R7", "tx_full before push", int'(tx_full), 0);
      tx_data = tx_byte(i); tx_push = 1'b1;
    end
    @(negedge clk);
    tx_push = 1'b0;
    chk_eq("R7", "tx_full at four ahead", int'(tx_full), 1);
    tx_data = 8'hFF; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
    repeat (300) @(negedge clk);
    chk_eq("R7", "rises for four bytes only", rise_cnt - base, 32);
    chk_eq("R7", "tx_full held with rx unread", int'(tx_full), 1);
    pop1("R10", int'(slave_byte(0)));
    chk_eq("R7", "tx_full after one pop", int'(tx_full), 0);
    for (int i = 1; i < 4; i++) pop1("R10", int'(slave_byte(i)));
    chk_eq("R10", "rx_empty after drain", int'(rx_empty), 1);
    @(negedge clk);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_eq("R10", "tx_full before push after empty pop", int'(tx_full), 0);
      tx_data = tx_byte(i + 4); tx_push = 1'b1;
    end
    @(negedge clk);
    tx_push = 1'b0;
    chk_eq("R10", "tx_full after four pushes", int'(tx_full), 1);
    repeat (300) @(negedge clk);
    for (int i = 4; i < 8; i++) pop1("R10", int'(slave_byte(i)));

    // R8 stall at word boundary
    good_cfg(2'd0, 16'd2, 8'd0);
    slave_sync();
    push1(tx_byte(0));
    chk_eq("R8", "busy while shifting", int'(busy), 1);
    repeat (200) @(negedge clk);
    chk_eq("R8", "busy after single word", int'(busy), 0);
    chk_eq("R8", "sclk parked low", int'(sclk), 0);
    chk_eq("R8", "rises after one word", rise_cnt - base, 8);
    repeat (100) @(negedge clk);
    chk_eq("R8", "no rises while stalled", rise_cnt - base, 8);
    pop1("R8", int'(slave_byte(0)));
    push1(tx_byte(1));
    repeat (200) @(negedge clk);
    chk_eq("R8", "rises after resume", rise_cnt - base, 16);
    pop1("R8", int'(slave_byte(1)));

    // R9 flush mid-transfer
    good_cfg(2'd3, 16'd3, 8'd0);
    slave_sync();
    for (int i = 0; i < 3; i++) push1(tx_byte(i));
    repeat (20) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk_eq("R9", "rx_empty after flush", int'(rx_empty), 1);
    chk_eq("R9", "tx_full after flush", int'(tx_full), 0);
    chk_eq("R9", "busy after flush", int'(busy), 0);
    chk_eq("R9", "mosi after flush", int'(mosi), 0);
    repeat (2) @(negedge clk);
    chk_eq("R9", "sclk idle after flush", int'(sclk), 1);
    r = rise_cnt;
    repeat (200) @(negedge clk);
    chk_eq("R9", "no rises after flush", rise_cnt, r);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule